// File: doc/BRIEF.md
# Multiplexed Expansion Bus Interface

This block sits between an 8-bit processor and the chip's external pins. When reset is released it keeps the last values seen on two mode-select inputs and holds one of four operating modes until the next reset. In the two pin-as-port modes, a high port and a shared port act as general-purpose parallel I/O. Each port has a data register and a direction register that the processor reaches through a small register window. In the two bus modes, the same pins carry an external memory bus. The high port drives address bits 15..8. The shared port carries address bits 7..0 and the data byte, one after the other. An address strobe and a read/write line complete the 18-pin bus.

The processor side is a valid/ready request port with a one-cycle response pulse. Every request runs the same two-phase pin cycle in the bus modes, whether it targets the external bus, the on-chip RAM or the port registers. Reads of on-chip targets take their data from inside the block and never from the pins. Each pin is split into an output value, an output enable and an input value, so the pad ring can build the tri-state drivers.

Top module: `mux_bus_if`

## Requirements
- R1: `mode_o` reports {mode_b, mode_a} as sampled on the last rising clock edge with `rst_n` low, and holds it until the next reset. The encoding is 00 bootstrap, 01 test, 10 single-chip and 11 expanded.
- R2: In modes 00 and 10 the pins are plain I/O. `hi_out`/`hi_oe` equal the high data/direction registers, `ad_out`/`ad_oe` equal the shared data/direction registers (a direction bit of 1 means output), `as_o` is 0 and `rw_o` is 1.
- R3: The port registers sit at REG_BASE (default 0x1000): +0 high data, +1 high direction, +2 shared data, +3 shared direction. They reset to 0. A read of a data register returns the register bit where the direction bit is 1 and the pin input where it is 0.
- R4: On-chip RAM spans RAM_DEPTH bytes from RAM_BASE (default 64 bytes from 0x0080). It resets to zero and can be written and read back at both ends of the range.
- R5: A request is taken on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is high only while the block is idle. `rsp_valid` is high for exactly one cycle, beginning at the second clock edge after the accepting edge, and `req_ready` is high again in that same cycle.
- R6: In modes 01 and 11, `hi_oe` is all ones and `hi_out` holds address bits 15..8 of the current or most recent request (0 after reset).
- R7: In the bus modes, the cycle after acceptance is the address phase: `as_o` = 1, `ad_out` = address bits 7..0 with `ad_oe` all ones, and `rw_o` = 1 for a read or 0 for a write. `rw_o` keeps that value through the data phase.
- R8: The data phase follows the address phase, with `as_o` = 0. A write drives the write byte on `ad_out` with `ad_oe` all ones. A read sets `ad_oe` to zero.
- R9: An external read in a bus mode returns the value of `ad_in` at the clock edge that ends the data phase.
- R10: In the bus modes, accesses to RAM or to the port registers still run the full pin cycle of R7/R8. Their reads return the on-chip value, whatever `ad_in` holds.
- R11: In modes 00 and 10, a read outside the on-chip ranges returns 0xFF. A write there changes no register and no pin.
- R12: In a bus mode with no access in progress, `as_o` = 0, `rw_o` = 1 and `ad_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_b | input | 1 | Mode select, upper bit |
| mode_a | input | 1 | Mode select, lower bit |
| req_valid | input | 1 | Processor request valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 8 | Read data (0 for writes) |
| mode_o | output | 2 | Latched operating mode |
| hi_in | input | 8 | High port pin inputs |
| hi_out | output | 8 | High port pin outputs |
| hi_oe | output | 8 | High port output enables |
| ad_in | input | 8 | Shared port pin inputs |
| ad_out | output | 8 | Shared port pin outputs |
| ad_oe | output | 8 | Shared port output enables |
| as_o | output | 1 | Address strobe |
| rw_o | output | 1 | Read (1) / write (0) |

## Verification
Relative to the accepting clock edge, the address phase pins are due in the next cycle. The data phase pins follow one cycle later, and the response pulse with its read data comes after the second edge. Register and RAM writes become visible at that same second edge. The bench keeps a behavioural model that it advances on each rising edge from the inputs it drove at the preceding falling edge. On every falling edge it compares every output against the model, so each result is checked in exactly the cycle it is due. Read data on the shared pins is driven before acceptance and left unchanged until after the edge that ends the data phase, so the sampled value is unambiguous.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    MODE_BOOT   = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_EXP    = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Modes whose lower select bit is set use the pins as a bus.
  function automatic logic mode_is_bus(input mode_e m);
    return m[0];
  endfunction

  // Output bits come from the register, input bits from the pins.
  function automatic logic [DATA_W-1:0] port_view(input logic [DATA_W-1:0] dir,
                                                  input logic [DATA_W-1:0] data,
                                                  input logic [DATA_W-1:0] pin);
    return (dir & data) | (~dir & pin);
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base,
                                     input int unsigned        size);
    logic [ADDR_W:0] lo;
    logic [ADDR_W:0] hi;
    logic [ADDR_W:0] x;
    lo = {1'b0, base};
    hi = lo + (ADDR_W+1)'(size);
    x  = {1'b0, a};
    return (x >= lo) && (x < hi);
  endfunction
endpackage

// File: rtl/mbus_mode_latch.sv
module mbus_mode_latch
  import mbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_b,
  input  logic  mode_a,
  output mode_e mode_q
);
  // Keeps loading while reset is low; the last load before release is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_e'({mode_b, mode_a});
  end
endmodule

// File: rtl/mbus_port_regs.sv
module mbus_port_regs
  import mbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hi_pin,
  input  logic [DATA_W-1:0] ad_pin,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] hi_data,
  output logic [DATA_W-1:0] hi_dir,
  output logic [DATA_W-1:0] ad_data,
  output logic [DATA_W-1:0] ad_dir
);
  localparam int NUM_REGS = 4;
  localparam logic [ADDR_W-1:0] A_HI_DATA = REG_BASE;
  localparam logic [ADDR_W-1:0] A_HI_DIR  = REG_BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_AD_DATA = REG_BASE + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_AD_DIR  = REG_BASE + ADDR_W'(3);

  assign hit = in_window(addr, REG_BASE, NUM_REGS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_data <= '0;
      hi_dir  <= '0;
      ad_data <= '0;
      ad_dir  <= '0;
    end else if (wr_en) begin
      if (addr == A_HI_DATA) hi_data <= wdata;
      if (addr == A_HI_DIR)  hi_dir  <= wdata;
      if (addr == A_AD_DATA) ad_data <= wdata;
      if (addr == A_AD_DIR)  ad_dir  <= wdata;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == A_HI_DATA) rd_data = port_view(hi_dir, hi_data, hi_pin);
    if (addr == A_HI_DIR)  rd_data = hi_dir;
    if (addr == A_AD_DATA) rd_data = port_view(ad_dir, ad_data, ad_pin);
    if (addr == A_AD_DIR)  rd_data = ad_dir;
  end
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram
  import mbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_BASE  = 16'h0080,
  parameter int                RAM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

  logic [DATA_W-1:0] mem [RAM_DEPTH];
  logic [IDX_W-1:0]  idx;

  assign hit     = in_window(addr, RAM_BASE, RAM_DEPTH);
  assign idx     = IDX_W'(addr - RAM_BASE);
  assign rd_data = hit ? mem[idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && hit) begin
      mem[idx] <= wdata;
    end
  end
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rd_src,
  output logic              req_ready,
  output phase_e            phase,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_write,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign req_ready = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cur_addr  <= '0;
      cur_write <= 1'b0;
      cur_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          cur_addr  <= req_addr;
          cur_write <= req_write;
          cur_wdata <= req_wdata;
          phase     <= PH_ADDR;
        end
        PH_ADDR: phase <= PH_DATA;
        PH_DATA: begin
          phase     <= PH_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= cur_write ? '0 : rd_src;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mux_bus_if.sv
module mux_bus_if
  import mbus_pkg::*;
#(
  parameter logic [15:0] REG_BASE  = 16'h1000,
  parameter logic [15:0] RAM_BASE  = 16'h0080,
  parameter int          RAM_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_b,
  input  logic        mode_a,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  output logic [1:0]  mode_o,
  input  logic [7:0]  hi_in,
  output logic [7:0]  hi_out,
  output logic [7:0]  hi_oe,
  input  logic [7:0]  ad_in,
  output logic [7:0]  ad_out,
  output logic [7:0]  ad_oe,
  output logic        as_o,
  output logic        rw_o
);
  localparam logic [DATA_W-1:0] ALL_OUT = '1;
  localparam logic [DATA_W-1:0] NO_HIT  = '1;

  mode_e             mode_q;
  phase_e            phase;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write;
  logic [DATA_W-1:0] cur_wdata;
  logic [DATA_W-1:0] rd_src;
  logic              reg_hit, ram_hit;
  logic [DATA_W-1:0] reg_rd, ram_rd;
  logic [DATA_W-1:0] hi_data, hi_dir, ad_data, ad_dir;

  // Named events for the checker.
  logic bus_mode, ph_addr, ph_data, commit_wr;
  assign bus_mode  = mode_is_bus(mode_q);
  assign ph_addr   = (phase == PH_ADDR);
  assign ph_data   = (phase == PH_DATA);
  assign commit_wr = ph_data && cur_write;

  mbus_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .mode_a(mode_a), .mode_q(mode_q)
  );

  mbus_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_src(rd_src), .req_ready(req_ready), .phase(phase),
    .cur_addr(cur_addr), .cur_write(cur_write), .cur_wdata(cur_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  mbus_port_regs #(.REG_BASE(REG_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(commit_wr), .addr(cur_addr), .wdata(cur_wdata),
    .hi_pin(hi_in), .ad_pin(ad_in), .hit(reg_hit), .rd_data(reg_rd),
    .hi_data(hi_data), .hi_dir(hi_dir), .ad_data(ad_data), .ad_dir(ad_dir)
  );

  mbus_ram #(.RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(commit_wr), .addr(cur_addr), .wdata(cur_wdata),
    .hit(ram_hit), .rd_data(ram_rd)
  );

  // On-chip sources win; the pins are sampled only for external reads.
  always_comb begin
    if (reg_hit)       rd_src = reg_rd;
    else if (ram_hit)  rd_src = ram_rd;
    else if (bus_mode) rd_src = ad_in;
    else               rd_src = NO_HIT;
  end

  assign mode_o = mode_q;

  always_comb begin
    if (bus_mode) begin
      hi_out = cur_addr[ADDR_W-1:DATA_W];
      hi_oe  = ALL_OUT;
      as_o   = ph_addr;
      rw_o   = (phase == PH_IDLE) ? 1'b1 : !cur_write;
      ad_out = ph_addr ? cur_addr[DATA_W-1:0] : cur_wdata;
      ad_oe  = (ph_addr || commit_wr) ? ALL_OUT : '0;
    end else begin
      hi_out = hi_data;
      hi_oe  = hi_dir;
      as_o   = 1'b0;
      rw_o   = 1'b1;
      ad_out = ad_data;
      ad_oe  = ad_dir;
    end
  end
endmodule

// File: rtl/mbus_chk.sv
module mbus_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic       bus_mode,
  input logic       ph_addr,
  input logic       ph_data,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       as_o,
  input logic       rw_o,
  input logic [7:0] hi_oe,
  input logic [7:0] ad_oe
);
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_o));
  // R2
  port_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> (!as_o && rw_o));
  // R5
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_addr || ph_data) |-> !req_ready);
  // R5
  rsp_after_phases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(ph_data) && $past(ph_addr, 2)));
  // R6
  hi_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> (hi_oe == 8'hFF));
  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_o |=> (!as_o && $stable(rw_o)));
  // R8
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && ph_data && rw_o) |-> (ad_oe == 8'h00));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && !ph_addr && !ph_data) |-> (!as_o && rw_o && ad_oe == 8'h00));
endmodule

bind mux_bus_if mbus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .bus_mode(bus_mode),
  .ph_addr(ph_addr), .ph_data(ph_data), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .as_o(as_o), .rw_o(rw_o), .hi_oe(hi_oe), .ad_oe(ad_oe)
);

// File: tb/tb_mux_bus_if.sv
`timescale 1ns/1ps
module tb_mux_bus_if;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n = 0, mode_b = 1, mode_a = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0, hi_in = 8'h5A, ad_in = 8'h00;
  logic req_ready, rsp_valid, as_o, rw_o;
  logic [7:0] rsp_rdata, hi_out, hi_oe, ad_out, ad_oe;
  logic [1:0] mode_o;

  mux_bus_if dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [1:0]  m_mode;
  int          m_ph;            // 0 idle, 1 address, 2 data
  logic [15:0] m_addr;
  logic        m_we;
  logic [7:0]  m_wd;
  logic        m_rsp;
  logic [7:0]  m_rdata;
  string       m_tag;
  logic [7:0]  m_hd, m_hr, m_ad, m_ar;
  logic [7:0]  m_ram [64];

  function automatic bool_bus(input logic [1:0] m); return m[0]; endfunction
  function automatic int kind(input logic [15:0] a);   // 1 reg, 2 ram, 0 other
    int x = int'(a);
    if (x >= 'h1000 && x <= 'h1003) return 1;
    if (x >= 'h80 && x < 'h80 + 64) return 2;
    return 0;
  endfunction
  function automatic logic [7:0] mixv(input logic [7:0] d, r, p);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = r[b] ? d[b] : p[b];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = {mode_b, mode_a};
      m_ph = 0; m_addr = 0; m_we = 0; m_wd = 0; m_rsp = 0; m_rdata = 0;
      m_hd = 0; m_hr = 0; m_ad = 0; m_ar = 0;
      for (int i = 0; i < 64; i++) m_ram[i] = 0;
    end else begin
      m_rsp = 0;
      if (m_ph == 0) begin
        if (req_valid) begin
          m_addr = req_addr; m_we = req_write; m_wd = req_wdata; m_ph = 1;
        end
      end else if (m_ph == 1) m_ph = 2;
      else begin
        m_ph = 0; m_rsp = 1;
        case (kind(m_addr))
          1: begin
            m_tag = bool_bus(m_mode) ? "R10" : "R3";
            if (m_we) begin
              case (m_addr[1:0]) 0: m_hd = m_wd; 1: m_hr = m_wd; 2: m_ad = m_wd; default: m_ar = m_wd; endcase
            end else begin
              case (m_addr[1:0]) 0: m_rdata = mixv(m_hd, m_hr, hi_in); 1: m_rdata = m_hr;
                2: m_rdata = mixv(m_ad, m_ar, ad_in); default: m_rdata = m_ar; endcase
            end
          end
          2: begin
            m_tag = bool_bus(m_mode) ? "R10" : "R4";
            if (m_we) m_ram[m_addr - 16'h80] = m_wd;
            else m_rdata = m_ram[m_addr - 16'h80];
          end
          default: begin
            m_tag = bool_bus(m_mode) ? "R9" : "R11";
            if (!m_we) m_rdata = bool_bus(m_mode) ? ad_in : 8'hFF;
          end
        endcase
      end
    end
  end

  // -------------- per-cycle comparison --------------
  always @(negedge clk) if (rst_n && !done) begin
    chk(mode_o == m_mode, "R1", "mode_o", mode_o, m_mode);
    chk(req_ready == (m_ph == 0), "R5", "req_ready", req_ready, m_ph == 0);
    chk(rsp_valid == m_rsp, "R5", "rsp_valid", rsp_valid, m_rsp);
    if (m_rsp && !m_we) chk(rsp_rdata == m_rdata, m_tag, "rsp_rdata", rsp_rdata, m_rdata);
    if (bool_bus(m_mode)) begin
      chk(hi_oe == 8'hFF && hi_out == m_addr[15:8], "R6", "hi_out", hi_out, m_addr[15:8]);
      if (m_ph == 0) begin
        chk(!as_o && rw_o && ad_oe == 0, "R12", "idle as/rw/ad_oe",
            {as_o, rw_o, ad_oe}, {2'b01, 8'h00});
      end else if (m_ph == 1) begin
        chk(as_o && rw_o == !m_we, "R7", "as/rw", {as_o, rw_o}, {1'b1, !m_we});
        chk(ad_oe == 8'hFF && ad_out == m_addr[7:0], "R7", "ad address", ad_out, m_addr[7:0]);
      end else begin
        chk(!as_o && rw_o == !m_we, "R8", "as/rw", {as_o, rw_o}, {1'b0, !m_we});
        if (m_we) chk(ad_oe == 8'hFF && ad_out == m_wd, "R8", "ad write data", ad_out, m_wd);
        else      chk(ad_oe == 8'h00, "R8", "ad_oe on read", ad_oe, 0);
      end
    end else begin
      chk(!as_o && rw_o, "R2", "as/rw", {as_o, rw_o}, 2'b01);
      chk(hi_out == m_hd && hi_oe == m_hr, "R2", "hi pins", {hi_out, hi_oe}, {m_hd, m_hr});
      chk(ad_out == m_ad && ad_oe == m_ar, "R2", "ad pins", {ad_out, ad_oe}, {m_ad, m_ar});
    end
  end

  // ---------------- stimulus ----------------
  task automatic reset_into(input logic [1:0] md);
    @(negedge clk);
    rst_n = 0; {mode_b, mode_a} = md;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    {mode_b, mode_a} = ~md;   // R1: later changes must not matter
    repeat (2) @(negedge clk);
    chk(mode_o == md, "R1", "mode held after release", mode_o, md);
    chk(rsp_valid == 0 && req_ready == 1, "R5", "reset idle", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic access(input logic [15:0] a, input logic we, input logic [7:0] wd,
                        input logic [7:0] pin, output logic [7:0] rd);
    req_valid = 1; req_write = we; req_addr = a; req_wdata = wd; ad_in = pin;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    rd = rsp_rdata;
  endtask

  logic [7:0] r;
  initial begin
    // Single-chip mode: port registers and RAM
    reset_into(2'b10);
    access(16'h1001, 0, 0, 0, r); chk(r == 0, "R3", "dir reset", r, 0);
    access(16'h1001, 1, 8'hFF, 0, r);
    access(16'h1000, 1, 8'hA5, 0, r);
    access(16'h1003, 1, 8'h0F, 0, r);
    access(16'h1002, 1, 8'h3C, 0, r);
    chk(hi_out == 8'hA5 && hi_oe == 8'hFF, "R2", "hi port output", hi_out, 8'hA5);
    access(16'h1002, 0, 0, 8'hF0, r); chk(r == 8'hFC, "R3", "mixed port read", r, 8'hFC);
    access(16'h0080, 1, 8'h11, 0, r);
    access(16'h00BF, 1, 8'h22, 0, r);
    access(16'h0080, 0, 0, 0, r); chk(r == 8'h11, "R4", "ram low end", r, 8'h11);
    access(16'h00BF, 0, 0, 0, r); chk(r == 8'h22, "R4", "ram high end", r, 8'h22);
    access(16'h00C0, 0, 0, 8'h33, r); chk(r == 8'hFF, "R11", "read past ram", r, 8'hFF);
    access(16'h1004, 0, 0, 8'h33, r); chk(r == 8'hFF, "R11", "read past regs", r, 8'hFF);
    access(16'h2000, 1, 8'h00, 0, r);
    chk(hi_out == 8'hA5 && ad_out == 8'h3C, "R11", "unmapped write no effect", hi_out, 8'hA5);
    // Bootstrap: pins as ports, registers back at reset value
    reset_into(2'b00);
    access(16'h1000, 0, 0, 0, r); chk(r == 8'h5A, "R3", "input port reads pins", r, 8'h5A);
    access(16'h1003, 1, 8'hC3, 0, r);
    chk(ad_oe == 8'hC3 && !as_o, "R2", "boot ad dir", ad_oe, 8'hC3);
    // Expanded mode
    reset_into(2'b11);
    access(16'h4321, 1, 8'h5A, 0, r);
    access(16'h8001, 0, 0, 8'h99, r); chk(r == 8'h99, "R9", "external read", r, 8'h99);
    access(16'h0090, 1, 8'h77, 0, r);
    access(16'h0090, 0, 0, 8'h11, r); chk(r == 8'h77, "R10", "internal ram read", r, 8'h77);
    access(16'h1001, 1, 8'h81, 0, r);
    access(16'h1001, 0, 0, 8'hEE, r); chk(r == 8'h81, "R10", "internal reg read", r, 8'h81);
    // Back-to-back requests
    req_valid = 1; req_write = 0; req_addr = 16'hFFFF; ad_in = 8'h42;
    repeat (7) @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    // Test mode behaves as a bus
    reset_into(2'b01);
    access(16'h00FF, 0, 0, 8'h6B, r); chk(r == 8'h6B, "R9", "test mode external read", r, 8'h6B);
    chk(hi_out == 8'h00 && hi_oe == 8'hFF, "R6", "test mode high byte", hi_out, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule